// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

This block gathers message-signalled interrupts into a small set of shared status banks. A sender posts a message by writing one word to the trigger register. The top bits of that word choose a bank, and the next bits choose one bit inside that bank. The chosen bit is ORed into the bank, and the bank's interrupt request line goes high. Each bank drives one request line, which stays high while the bank holds any set bit.

The handler reads the bank named by its request line. The read returns the pending bits, clears the bank to zero and drops the line, so one read both collects and acknowledges every message in the bank. A summary register shows which banks are non-zero and does not clear anything. Reads and writes use separate request channels, so a read and a write can happen in the same cycle. When both hit the same bank, the message being written is kept.

Top module: `msg_irq_collector`

## Requirements
- R1: After reset every request line is low, the read-valid output is low and every bank reads as zero.
- R2: An aligned write to offset 0x140 selects bank wr_data[31:29] and bit wr_data[28:24], ORs that bit into the bank, and raises that bank's request line on the first rising edge after the write.
- R3: A read of bank b is made at offset 0x10*b (0x00 to 0x70). It returns the bank contents on rd_data, with rd_valid high, one cycle after the request.
- R4: A bank read clears that bank to zero and drops its request line on the same edge that captures the read data.
- R5: A read of offset 0x120 returns a bitmap whose bit i is set when bank i is non-zero, with all upper bits zero. This read leaves every bank unchanged.
- R6: An access whose address bits 3:0 are not zero is ignored. A read of such an address returns all ones and clears nothing, and a write there sets nothing.
- R7: A write to any offset other than 0x140 (bank offsets and 0x120 included) changes no bank and no request line.
- R8: When a trigger write and a read of the same bank fall in one cycle, the read returns the bank contents before the write. The written bit survives, and the bank's request line stays high.
- R9: An aligned read of any offset that is not a bank or the summary (0x140 included) returns zero.
- R10: Bits accumulate: successive triggers to one bank set several bits, and a repeated trigger of a bit that is already set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_valid | output | 1 | Read data is present, one cycle after rd_en |
| rd_data | output | DATA_W | Read data |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data; the trigger fields are in the top bits |
| irq | output | NUM_BANKS | Per-bank interrupt request, high while the bank is non-zero |

## Verification
Every result of this block is due one rising edge after its stimulus. A trigger write sets the bit and raises the request line on that edge. A read captures its data, asserts rd_valid and clears the bank on that edge, and the request line falls on the same edge. The bench drives its inputs on falling edges and compares the outputs with its reference model on the next falling edge, which is exactly one register stage after the stimulus. The directed checks sample rd_data at that same falling edge. Same-cycle read and write collisions are driven in a single falling-edge slot, so the outcome in which the set wins appears in the very next comparison.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
  localparam int ALIGN_BITS  = 4;
  localparam int OFF_SUMMARY = 'h120;
  localparam int OFF_TRIGGER = 'h140;

  typedef enum logic [1:0] {
    RK_ZERO   = 2'd0,
    RK_STATUS = 2'd1,
    RK_SUMMARY = 2'd2,
    RK_ONES   = 2'd3
  } rd_kind_t;
endpackage

// File: rtl/msgirq_rstsync.sv
module msgirq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/msgirq_decode.sv
module msgirq_decode
  import msgirq_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8
) (
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output rd_kind_t                   rd_kind,
  output logic [$clog2(NUM_BANKS)-1:0] rd_bank,
  output logic [NUM_BANKS-1:0]       clr_hit,
  output logic [NUM_BANKS-1:0]       set_hit,
  output logic [DATA_W-1:0]          set_mask
);
  localparam int SEL_W   = $clog2(NUM_BANKS);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int SEL_LSB = DATA_W - SEL_W;
  localparam int IDX_LSB = SEL_LSB - IDX_W;
  localparam int SLOT_W  = ADDR_W - ALIGN_BITS;

  logic [SLOT_W-1:0] rd_slot;
  logic              rd_aligned;
  logic              trig_hit;
  logic [SEL_W-1:0]  wr_bank;
  logic [IDX_W-1:0]  wr_bit;

  assign rd_slot    = rd_addr[ADDR_W-1:ALIGN_BITS];
  assign rd_aligned = (rd_addr[ALIGN_BITS-1:0] == '0);
  assign rd_bank    = rd_slot[SEL_W-1:0];
  assign trig_hit   = wr_en && (wr_addr == ADDR_W'(OFF_TRIGGER));
  assign wr_bank    = wr_data[SEL_LSB +: SEL_W];
  assign wr_bit     = wr_data[IDX_LSB +: IDX_W];
  assign set_mask   = DATA_W'(1) << wr_bit;

  always_comb begin
    if (!rd_aligned)                          rd_kind = RK_ONES;
    else if (rd_slot < SLOT_W'(NUM_BANKS))    rd_kind = RK_STATUS;
    else if (rd_addr == ADDR_W'(OFF_SUMMARY)) rd_kind = RK_SUMMARY;
    else                                      rd_kind = RK_ZERO;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign clr_hit[b] = rd_en && (rd_kind == RK_STATUS) && (rd_bank == SEL_W'(b));
    assign set_hit[b] = trig_hit && (wr_bank == SEL_W'(b));
  end
endmodule

// File: rtl/msgirq_bank.sv
module msgirq_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_mask,
  input  logic              clr_en,
  output logic [DATA_W-1:0] bits_q,
  output logic              req
);
  logic [DATA_W-1:0] bits_d;
  logic              upd;

  assign upd = set_en | clr_en;

  always_comb begin
    bits_d = clr_en ? '0 : bits_q;
    if (set_en) bits_d = bits_d | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_d;
  end

  assign req = |bits_q;
endmodule

// File: rtl/msgirq_rdport.sv
module msgirq_rdport
  import msgirq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_en,
  input  rd_kind_t                            rd_kind,
  input  logic [$clog2(NUM_BANKS)-1:0]        rd_bank,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_bits,
  input  logic [NUM_BANKS-1:0]                bank_req,
  output logic                                rd_valid,
  output logic [DATA_W-1:0]                   rd_data
);
  logic [DATA_W-1:0] data_d;

  always_comb begin
    unique case (rd_kind)
      RK_STATUS:  data_d = bank_bits[rd_bank];
      RK_SUMMARY: data_d = DATA_W'(bank_req);
      RK_ONES:    data_d = '1;
      default:    data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= data_d;
  end
endmodule

// File: rtl/msg_irq_collector.sv
module msg_irq_collector
  import msgirq_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_BANKS-1:0] irq
);
  localparam int SEL_W = $clog2(NUM_BANKS);

  logic                             rst_q_n;
  rd_kind_t                         rd_kind;
  logic [SEL_W-1:0]                 rd_bank;
  logic [NUM_BANKS-1:0]             clr_hit;
  logic [NUM_BANKS-1:0]             set_hit;
  logic [DATA_W-1:0]                set_mask;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_bits;

  msgirq_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  msgirq_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_dec (
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_kind  (rd_kind),
    .rd_bank  (rd_bank),
    .clr_hit  (clr_hit),
    .set_hit  (set_hit),
    .set_mask (set_mask)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    msgirq_bank #(.DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .set_en   (set_hit[b]),
      .set_mask (set_mask),
      .clr_en   (clr_hit[b]),
      .bits_q   (bank_bits[b]),
      .req      (irq[b])
    );
  end

  msgirq_rdport #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rd_en     (rd_en),
    .rd_kind   (rd_kind),
    .rd_bank   (rd_bank),
    .bank_bits (bank_bits),
    .bank_req  (irq),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/msgirq_checker.sv
module msgirq_checker
  import msgirq_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rst_ok_n,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic                 rd_valid,
  input logic [DATA_W-1:0]    rd_data,
  input logic [NUM_BANKS-1:0] irq
);
  localparam int SEL_W  = $clog2(NUM_BANKS);
  localparam int SLOT_W = ADDR_W - ALIGN_BITS;

  logic             trig;
  logic [SEL_W-1:0] trig_bank;
  logic             bank_rd;

  assign trig      = wr_en && (wr_addr == ADDR_W'(OFF_TRIGGER));
  assign trig_bank = wr_data[DATA_W-1 -: SEL_W];
  assign bank_rd   = rd_en && (rd_addr[ALIGN_BITS-1:0] == '0) &&
                     (rd_addr[ADDR_W-1:ALIGN_BITS] < SLOT_W'(NUM_BANKS));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R2, R8: a trigger always leaves its bank requesting
    a_r2_trigger_raises: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (trig && trig_bank == SEL_W'(b)) |=> irq[b]);
    // R4: a read with no competing trigger empties the bank
    a_r4_read_drops: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (rd_en && rd_addr == ADDR_W'(b << ALIGN_BITS) &&
       !(trig && trig_bank == SEL_W'(b))) |=> !irq[b]);
  end

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rd_en |=> rd_valid);
  a_r3_valid_idle: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rd_en |=> !rd_valid);
  a_r5_summary_map: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rd_en && rd_addr == ADDR_W'(OFF_SUMMARY)) |=> rd_data == DATA_W'($past(irq)));
  a_r6_misaligned_ones: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rd_en && rd_addr[ALIGN_BITS-1:0] != '0) |=> rd_data == '1);
  // R6, R7: with no trigger and no bank read the lines hold
  a_r7_lines_hold: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!trig && !bank_rd) |=> $stable(irq));
endmodule

bind msg_irq_collector msgirq_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_BANKS (NUM_BANKS)
) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_q_n),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/msg_irq_collector_tb_top.sv
`timescale 1ns/1ps
module msg_irq_collector_tb_top;
  localparam int AW = 9;
  localparam int DW = 32;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] irq;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  msg_irq_collector #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  // behavioural reference model
  logic [DW-1:0] m_bank [NB];
  logic [DW-1:0] m_rdata;
  bit            m_rvalid;
  int            rst_cnt;

  function automatic logic [NB-1:0] m_irq();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = (m_bank[i] != 0);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || rst_cnt < 2) begin
      if (!rst_n) rst_cnt = 0; else rst_cnt = rst_cnt + 1;
      for (int i = 0; i < NB; i++) m_bank[i] = 0;
      m_rvalid = 0;
      m_rdata  = 0;
    end else begin
      logic [NB-1:0] snap;
      int            clr;
      snap     = m_irq();
      clr      = -1;
      m_rvalid = rd_en;
      if (rd_en) begin
        if (rd_addr % 16 != 0)      m_rdata = 32'hFFFF_FFFF;
        else if (rd_addr < NB * 16) begin
          m_rdata = m_bank[rd_addr / 16];
          clr     = rd_addr / 16;
        end
        else if (rd_addr == 'h120)  m_rdata = DW'(snap);
        else                        m_rdata = 0;
      end
      if (clr >= 0) m_bank[clr] = 0;
      if (wr_en && wr_addr == 'h140)
        m_bank[wr_data[31:29]] = m_bank[wr_data[31:29]] | (32'd1 << wr_data[28:24]);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (irq !== m_irq()) begin
        n_bad++;
        $display("FAIL %s irq actual=%h expected=%h", phase, irq, m_irq());
      end
      n_chk++;
      if (rd_valid !== m_rvalid || (m_rvalid && rd_data !== m_rdata)) begin
        n_bad++;
        $display("FAIL %s read actual=%0b/%h expected=%0b/%h",
                 phase, rd_valid, rd_data, m_rvalid, m_rdata);
      end
    end
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access slot: drive at a falling edge, result at the next one
  task automatic slot(bit we, int wa, logic [DW-1:0] wd, bit re, int ra,
                      output logic [DW-1:0] rd);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_en = re; rd_addr = AW'(ra);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    rd = rd_data;
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    logic [DW-1:0] x;
    slot(1, a, d, 0, 0, x);
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    slot(0, 0, 0, 1, a, d);
  endtask

  function automatic logic [DW-1:0] trg(int bank, int bitn);
    return (DW'(bank) << 29) | (DW'(bitn) << 24);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 0; rd_en = 0; wr_en = 0; rd_addr = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    phase = "R1";
    check("R1 irq", DW'(irq), 0);
    check("R1 valid", DW'(rd_valid), 0);
    for (int b = 0; b < NB; b++) begin
      rd(b * 16, d); check("R1 bank zero", d, 0);
    end

    phase = "R2";
    wr('h140, trg(3, 5));
    check("R2 irq bank3", DW'(irq), 'h08);

    phase = "R10";
    wr('h140, trg(3, 31));
    wr('h140, trg(3, 5));
    check("R10 irq", DW'(irq), 'h08);

    phase = "R3";
    rd('h30, d);
    check("R3 bank3 data", d, 32'h8000_0020);
    check("R3 valid", DW'(rd_valid), 1);
    check("R4 irq dropped", DW'(irq), 0);
    phase = "R4";
    rd('h30, d); check("R4 bank3 cleared", d, 0);

    phase = "R5";
    wr('h140, trg(0, 0));
    wr('h140, trg(7, 1));
    rd('h120, d); check("R5 summary", d, 'h81);
    rd('h120, d); check("R5 summary not cleared", d, 'h81);
    check("R5 irq", DW'(irq), 'h81);

    phase = "R6";
    rd('h004, d); check("R6 misaligned read", d, 32'hFFFF_FFFF);
    check("R6 irq kept", DW'(irq), 'h81);
    wr('h144, trg(1, 0));
    wr('h148, trg(2, 3));
    check("R6 misaligned write", DW'(irq), 'h81);
    rd('h10, d); check("R6 bank1 empty", d, 0);

    phase = "R7";
    wr('h000, 32'hFFFF_FFFF);
    wr('h120, 32'hFFFF_FFFF);
    wr('h100, trg(4, 4));
    check("R7 irq unchanged", DW'(irq), 'h81);
    rd('h00, d); check("R7 bank0 intact", d, 1);

    phase = "R9";
    rd('h140, d); check("R9 trigger reads zero", d, 0);
    rd('h0F0, d); check("R9 unmapped zero", d, 0);
    rd('h080, d); check("R9 past banks zero", d, 0);

    phase = "R8";
    slot(1, 'h140, trg(7, 4), 1, 'h70, d);
    check("R8 old contents", d, 'h2);
    check("R8 line held", DW'(irq[7]), 1);
    rd('h70, d); check("R8 bit survived", d, 'h10);
    check("R8 drained", DW'(irq), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule